// File: doc/BRIEF.md
# Successive-Approximation Sequencer with Three-Way LSB Voting

This block is the digital controller of a 9-bit charge-redistribution converter that carries one redundant step. After a start pulse it runs a conversion of fixed length. It marks a sampling window, then walks the capacitor array one step per cycle for the eight binary steps and the redundant step. For each of the two least-significant steps it fires the comparator four times. The four results are reduced to a digit of +1, 0 or -1. A tied vote leaves that capacitor untouched. In the final cycle it raises a strobe that tells the loop filter to capture the residue.

Each decided digit sets a 2-bit drive state for its capacitor. When the conversion ends, the block forms a signed code as the weighted sum of the digits. The code is presented with a one-cycle done pulse. The comparator, the capacitor array and the filter are analog and live outside the block. The comparator result must be valid in every cycle in which the fire strobe is high.

The code output has no back-pressure. It is a plain valid pulse with no ready. A consumer must take the code in the done cycle, or later but before the next done. The code register holds its value until the next conversion overwrites it.

Top module: `sar_vote_seq`

## Requirements
- R1: A conversion accepted on a start pulse lasts exactly 20 cycles, counted from the cycle after the accepting edge. The residue strobe `rescap_o` is high in cycle 20 only, whatever the comparator returns.
- R2: In cycles 1 and 2 `samp_o` is high and `fire_o` is low. Every capacitor drive state is mid (`00`) in those cycles.
- R3: Cycles 3 to 11 each fire the comparator once, for steps 0..8 in that order. The drive state of capacitor n sits in `dac_o[2n+1:2n]`, where step 0 is the heaviest binary step and step 8 is the redundant one. A comparator result of 1 gives digit +1 and drives the capacitor to -ref (`10`). A result of 0 gives digit -1 and drives it to +ref (`01`). The drive is visible in the following cycle.
- R4: Cycles 12 to 15 are the four votes of step 9, and cycles 16 to 19 are the four votes of step 10. Three or four ones give +1. Exactly two ones give 0. Zero or one ones give -1.
- R5: A digit of 0 switches nothing: that capacitor stays at mid (`00`) through the end of the conversion.
- R6: In cycle 20 the step-10 decision is visible on `dac_o`, `fire_o` is low, and the comparator has fired exactly 17 times in the conversion. `dac_o` does not change in the cycle after cycle 20.
- R7: `code_o` is the two's-complement sum of digit times weight. The weights are 128, 64, 32, 16, 8, 4, 2, 1 for steps 0..7, 16 for step 8, and 1 for steps 9 and 10. `done_o` is high for the one cycle after cycle 20, and the code stays held until the next done.
- R8: A start pulse in cycles 1..20 is ignored, and no new sampling follows it. A start in the done cycle is accepted, so conversions run back to back.
- R9: A synchronous reset returns the block to idle at the next edge. After it, all drive states are mid, all strobes and `done_o` are low, and `code_o` is zero.
- R10: At most one of `samp_o`, `fire_o`, `rescap_o`, `done_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a conversion when idle |
| comp_i | input | 1 | Comparator result, 1 means residue positive |
| dac_o | output | 22 | Two-bit drive state per capacitor: 00 mid, 01 +ref, 10 -ref |
| samp_o | output | 1 | Sampling window strobe |
| fire_o | output | 1 | Comparator fire strobe |
| rescap_o | output | 1 | Residue-capture strobe |
| code_o | output | 10 | Signed conversion result |
| done_o | output | 1 | One-cycle valid pulse for code_o |

## Verification
Two functions can fall in the same cycle: the done pulse of one conversion and the acceptance of the next start. The bench issues a start exactly in the done cycle. It then judges both sides: the finished code must be correct in that cycle, and the following cycle must begin a fresh sampling window. The opposite overlap is a start that lands in the residue-strobe cycle or mid-vote. That start must be swallowed, and the bench checks that the first idle cycle afterwards shows no sampling. All of this runs alongside a sweep of the analog input and all 256 vote-pattern pairs, with each code and drive state compared against values the bench computes.

// File: rtl/sar_vote_pkg.sv
package sar_vote_pkg;

  typedef enum logic [1:0] {
    DRV_MID = 2'b00,
    DRV_POS = 2'b01,
    DRV_NEG = 2'b10
  } drive_e;

  typedef logic signed [1:0] digit_t;

  localparam digit_t DIG_ZERO = 2'sb00;
  localparam digit_t DIG_UP   = 2'sb01;
  localparam digit_t DIG_DN   = 2'sb11;

  // weight of step idx: binary steps first, then the redundant step, then unit steps
  function automatic int step_weight(input int idx, input int msb_bits, input int red_w);
    if (idx < msb_bits) return 1 << (msb_bits - 1 - idx);
    else if (idx == msb_bits) return red_w;
    else return 1;
  endfunction

  function automatic int max_code(input int msb_bits, input int red_w, input int lsb_steps);
    return (1 << msb_bits) - 1 + red_w + lsb_steps;
  endfunction

  // a positive digit subtracts the capacitor's weight, a negative one adds it
  function automatic drive_e digit_drive(input digit_t d);
    if (d == DIG_UP) return DRV_NEG;
    else if (d == DIG_DN) return DRV_POS;
    else return DRV_MID;
  endfunction

endpackage

// File: rtl/sar_phase_timer.sv
module sar_phase_timer #(
  parameter int SAMP_CYC  = 2,
  parameter int ONE_SHOT  = 9,
  parameter int LSB_STEPS = 2,
  parameter int VOTES     = 4,
  parameter int STEP_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  output logic              accept_o,
  output logic              samp_o,
  output logic              shot_o,
  output logic              vote_o,
  output logic              vote_first_o,
  output logic              vote_last_o,
  output logic              last_o,
  output logic [STEP_W-1:0] step_o
);
  localparam int LAST_CYC   = SAMP_CYC + ONE_SHOT + LSB_STEPS * VOTES + 1;
  localparam int CYC_W      = $clog2(LAST_CYC + 1);
  localparam int FIRST_SHOT = SAMP_CYC + 1;
  localparam int FIRST_VOTE = FIRST_SHOT + ONE_SHOT;
  localparam int LAST_VOTE  = LAST_CYC - 1;

  logic             busy_q;
  logic [CYC_W-1:0] cyc_q;
  int               c_i;
  int               off_i;

  assign accept_o = start_i & ~busy_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cyc_q  <= CYC_W'(1);
    end else if (busy_q) begin
      if (int'(cyc_q) == LAST_CYC) begin
        busy_q <= 1'b0;
        cyc_q  <= '0;
      end else begin
        cyc_q <= cyc_q + CYC_W'(1);
      end
    end
  end

  always_comb begin
    c_i          = int'(cyc_q);
    off_i        = c_i - FIRST_VOTE;
    samp_o       = busy_q && (c_i >= 1) && (c_i <= SAMP_CYC);
    shot_o       = busy_q && (c_i >= FIRST_SHOT) && (c_i < FIRST_VOTE);
    vote_o       = busy_q && (c_i >= FIRST_VOTE) && (c_i <= LAST_VOTE);
    vote_first_o = vote_o && ((off_i % VOTES) == 0);
    vote_last_o  = vote_o && ((off_i % VOTES) == VOTES - 1);
    last_o       = busy_q && (c_i == LAST_CYC);
    if (shot_o)      step_o = STEP_W'(c_i - FIRST_SHOT);
    else if (vote_o) step_o = STEP_W'(ONE_SHOT + off_i / VOTES);
    else             step_o = '0;
  end

endmodule

// File: rtl/sar_vote_tally.sv
module sar_vote_tally
  import sar_vote_pkg::*;
#(
  parameter int VOTES = 4
) (
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   vote_i,
  input  logic   first_i,
  input  logic   last_i,
  input  logic   comp_i,
  output digit_t dig_o,
  output logic   dig_v_o
);
  localparam int CNT_W = $clog2(VOTES + 1);

  logic [CNT_W-1:0] cnt_q;
  int               tot_i;

  always_comb begin
    tot_i = (first_i ? 0 : int'(cnt_q)) + (comp_i ? 1 : 0);
    if (2 * tot_i > VOTES)       dig_o = DIG_UP;
    else if (2 * tot_i == VOTES) dig_o = DIG_ZERO;
    else                         dig_o = DIG_DN;
    dig_v_o = vote_i & last_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (vote_i) cnt_q <= CNT_W'(tot_i);
  end

endmodule

// File: rtl/sar_cap_bank.sv
module sar_cap_bank
  import sar_vote_pkg::*;
#(
  parameter int NSTEP  = 11,
  parameter int STEP_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 clear_i,
  input  logic                 wr_i,
  input  logic [STEP_W-1:0]    wr_idx_i,
  input  digit_t               wr_dig_i,
  output logic [2*NSTEP-1:0]   drive_o,
  output logic [2*NSTEP-1:0]   digs_o
);
  for (genvar g = 0; g < NSTEP; g++) begin : g_cap
    drive_e drv_q;
    digit_t dig_q;

    always_ff @(posedge clk_i) begin
      if (rst_i || clear_i) begin
        drv_q <= DRV_MID;
        dig_q <= DIG_ZERO;
      end else if (wr_i && (wr_idx_i == STEP_W'(g))) begin
        drv_q <= digit_drive(wr_dig_i);
        dig_q <= wr_dig_i;
      end
    end

    assign drive_o[2*g +: 2] = drv_q;
    assign digs_o[2*g +: 2]  = dig_q;
  end

endmodule

// File: rtl/sar_code_sum.sv
module sar_code_sum
  import sar_vote_pkg::*;
#(
  parameter int NSTEP    = 11,
  parameter int MSB_BITS = 8,
  parameter int RED_W    = 16,
  parameter int CODE_W   = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     load_i,
  input  logic [2*NSTEP-1:0]       digs_i,
  output logic signed [CODE_W-1:0] code_o,
  output logic                     done_o
);
  int sum_i;

  always_comb begin
    sum_i = 0;
    for (int i = 0; i < NSTEP; i++) begin
      sum_i = sum_i + int'(digit_t'(digs_i[2*i +: 2])) * step_weight(i, MSB_BITS, RED_W);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      code_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) code_o <= CODE_W'(sum_i);
    end
  end

endmodule

// File: rtl/sar_vote_seq.sv
module sar_vote_seq
  import sar_vote_pkg::*;
#(
  parameter  int MSB_BITS  = 8,
  parameter  int RED_W     = 16,
  parameter  int LSB_STEPS = 2,
  parameter  int VOTES     = 4,
  parameter  int SAMP_CYC  = 2,
  localparam int ONE_SHOT  = MSB_BITS + 1,
  localparam int NSTEP     = ONE_SHOT + LSB_STEPS,
  localparam int CODE_W    = $clog2(max_code(MSB_BITS, RED_W, LSB_STEPS) + 1) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     start_i,
  input  logic                     comp_i,
  output logic [2*NSTEP-1:0]       dac_o,
  output logic                     samp_o,
  output logic                     fire_o,
  output logic                     rescap_o,
  output logic signed [CODE_W-1:0] code_o,
  output logic                     done_o
);
  localparam int STEP_W = $clog2(NSTEP);

  logic              accept, shot, vote, vote_first, vote_last, last;
  logic [STEP_W-1:0] step;
  digit_t            tally_dig, wr_dig;
  logic              tally_v, wr;
  logic [2*NSTEP-1:0] digs;

  sar_phase_timer #(
    .SAMP_CYC (SAMP_CYC),
    .ONE_SHOT (ONE_SHOT),
    .LSB_STEPS(LSB_STEPS),
    .VOTES    (VOTES),
    .STEP_W   (STEP_W)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .accept_o    (accept),
    .samp_o      (samp_o),
    .shot_o      (shot),
    .vote_o      (vote),
    .vote_first_o(vote_first),
    .vote_last_o (vote_last),
    .last_o      (last),
    .step_o      (step)
  );

  sar_vote_tally #(.VOTES(VOTES)) u_tally (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .vote_i (vote),
    .first_i(vote_first),
    .last_i (vote_last),
    .comp_i (comp_i),
    .dig_o  (tally_dig),
    .dig_v_o(tally_v)
  );

  assign wr     = shot | tally_v;
  assign wr_dig = shot ? (comp_i ? DIG_UP : DIG_DN) : tally_dig;

  sar_cap_bank #(.NSTEP(NSTEP), .STEP_W(STEP_W)) u_caps (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .clear_i (accept),
    .wr_i    (wr),
    .wr_idx_i(step),
    .wr_dig_i(wr_dig),
    .drive_o (dac_o),
    .digs_o  (digs)
  );

  sar_code_sum #(
    .NSTEP   (NSTEP),
    .MSB_BITS(MSB_BITS),
    .RED_W   (RED_W),
    .CODE_W  (CODE_W)
  ) u_sum (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .load_i(last),
    .digs_i(digs),
    .code_o(code_o),
    .done_o(done_o)
  );

  assign fire_o   = shot | vote;
  assign rescap_o = last;

endmodule

// File: rtl/sar_vote_seq_chk.sv
module sar_vote_seq_chk #(
  parameter int NSTEP      = 11,
  parameter int SAMP_CYC   = 2,
  parameter int LAST_CYC   = 20,
  parameter int FIRE_TOTAL = 17
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               start_i,
  input logic [2*NSTEP-1:0] dac_o,
  input logic               samp_o,
  input logic               fire_o,
  input logic               rescap_o,
  input logic               done_o
);
  logic run_q;
  int   cnt_q;
  int   fires_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q   <= 1'b0;
      cnt_q   <= 0;
      fires_q <= 0;
    end else if (start_i && !run_q) begin
      run_q   <= 1'b1;
      cnt_q   <= 1;
      fires_q <= 0;
    end else if (run_q) begin
      if (cnt_q == LAST_CYC) begin
        run_q <= 1'b0;
        cnt_q <= 0;
      end else begin
        cnt_q <= cnt_q + 1;
      end
      if (fire_o) fires_q <= fires_q + 1;
    end
  end

  a_r1_strobe_at_end: assert property (@(posedge clk_i) disable iff (rst_i)
    rescap_o |-> (run_q && cnt_q == LAST_CYC));

  a_r1_end_has_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && cnt_q == LAST_CYC) |-> rescap_o);

  a_r2_samp_window: assert property (@(posedge clk_i) disable iff (rst_i)
    samp_o |-> (run_q && cnt_q <= SAMP_CYC && dac_o == '0));

  a_r6_fire_count: assert property (@(posedge clk_i) disable iff (rst_i)
    rescap_o |-> (fires_q == FIRE_TOTAL));

  a_r6_hold_after: assert property (@(posedge clk_i) disable iff (rst_i)
    rescap_o |=> $stable(dac_o));

  a_r7_done_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    rescap_o |=> done_o);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({samp_o, fire_o, rescap_o, done_o}));

  for (genvar g = 0; g < NSTEP; g++) begin : g_legal
    a_r3_drive_legal: assert property (@(posedge clk_i) disable iff (rst_i)
      dac_o[2*g +: 2] != 2'b11);
  end

endmodule

bind sar_vote_seq sar_vote_seq_chk #(
  .NSTEP     (NSTEP),
  .SAMP_CYC  (SAMP_CYC),
  .LAST_CYC  (SAMP_CYC + ONE_SHOT + LSB_STEPS * VOTES + 1),
  .FIRE_TOTAL(ONE_SHOT + LSB_STEPS * VOTES)
) i_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .start_i (start_i),
  .dac_o   (dac_o),
  .samp_o  (samp_o),
  .fire_o  (fire_o),
  .rescap_o(rescap_o),
  .done_o  (done_o)
);

// File: tb/test_sar_vote_seq.sv
`timescale 1ns/1ps
module test_sar_vote_seq;
  localparam int NSTEP = 11;

  logic        clk = 1'b0;
  logic        rst_i = 1'b1;
  logic        start_i = 1'b0;
  logic        comp_i;
  logic [21:0] dac_o;
  logic        samp_o, fire_o, rescap_o, done_o;
  logic signed [9:0] code_o;

  int checks = 0;
  int errors = 0;

  int       vin = 0;
  bit       forced = 1'b0;
  bit [3:0] pat1 = 4'h0, pat2 = 4'h0;
  int       fidx = 0;
  int       model_res;
  int       fires_seen;

  int          exp_dig [NSTEP];
  int          exp_code;
  logic [21:0] exp_dac;

  always #2 clk = ~clk;

  sar_vote_seq i_sar_vote_seq (
    .clk_i(clk), .rst_i(rst_i), .start_i(start_i), .comp_i(comp_i),
    .dac_o(dac_o), .samp_o(samp_o), .fire_o(fire_o), .rescap_o(rescap_o),
    .code_o(code_o), .done_o(done_o)
  );

  function automatic int wt(input int i);
    if (i < 8) return 1 << (7 - i);
    else if (i == 8) return 16;
    else return 1;
  endfunction

  // behavioural comparator: ideal sign of residue, or a forced vote pattern
  always @(posedge clk) begin
    if (samp_o) fidx <= 0;
    else if (fire_o) fidx <= fidx + 1;
  end

  always_comb begin
    model_res = vin;
    for (int i = 0; i < NSTEP; i++) begin
      if (dac_o[2*i +: 2] == 2'b01) model_res = model_res + wt(i);
      else if (dac_o[2*i +: 2] == 2'b10) model_res = model_res - wt(i);
    end
    if (forced && fidx >= 9 && fidx < 13)       comp_i = pat1[fidx - 9];
    else if (forced && fidx >= 13 && fidx < 17) comp_i = pat2[fidx - 13];
    else                                        comp_i = (model_res > 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic calc();
    int r;
    int ones;
    r = vin;
    exp_code = 0;
    exp_dac = '0;
    for (int i = 0; i < NSTEP; i++) begin
      if (i < 9) exp_dig[i] = (r > 0) ? 1 : -1;
      else begin
        if (forced) ones = $countones((i == 9) ? pat1 : pat2);
        else ones = (r > 0) ? 4 : 0;
        exp_dig[i] = (ones >= 3) ? 1 : ((ones == 2) ? 0 : -1);
      end
      r = r - exp_dig[i] * wt(i);
      exp_code = exp_code + exp_dig[i] * wt(i);
      if (exp_dig[i] == 1)       exp_dac[2*i +: 2] = 2'b10;
      else if (exp_dig[i] == -1) exp_dac[2*i +: 2] = 2'b01;
    end
  endtask

  // one conversion; inj: cycle in which a stray start is driven (0 none)
  task automatic conv(input int v, input bit f, input bit [3:0] p1, input bit [3:0] p2,
                      input int inj, input bit skip_start, input bit chain_out);
    vin = v; forced = f; pat1 = p1; pat2 = p2;
    calc();
    fires_seen = 0;
    if (!skip_start) begin
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    for (int k = 1; k <= 21; k++) begin
      if (fire_o) fires_seen++;
      if (k <= 2) begin
        chk(samp_o && !fire_o, "R2 sampling strobe", {samp_o, fire_o}, 2);
        chk(dac_o == '0, "R2 drives mid while sampling", int'(dac_o), 0);
      end else if (k <= 19) begin
        chk(fire_o && !rescap_o, "R1 fire in compare cycle", fire_o, 1);
      end else if (k == 20) begin
        chk(rescap_o && !fire_o && !done_o, "R1 residue strobe in cycle 20", rescap_o, 1);
        chk(dac_o == exp_dac, "R3 R4 R5 drive states at cycle 20", int'(dac_o), int'(exp_dac));
        chk(fires_seen == 17, "R6 firing count", fires_seen, 17);
      end else begin
        chk(done_o && !rescap_o, "R7 done pulse", done_o, 1);
        chk(int'(code_o) == exp_code, "R7 code value", int'(code_o), exp_code);
        chk(dac_o == exp_dac, "R6 drive held after strobe", int'(dac_o), int'(exp_dac));
      end
      if (k == inj) start_i = 1'b1;
      if (k == 21 && chain_out) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    if (!chain_out) begin
      chk(!samp_o && !fire_o && !done_o, "R8 idle after conversion", samp_o, 0);
    end
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dac_o == '0 && !samp_o && !fire_o && !rescap_o && !done_o && code_o == '0,
        "R9 reset state", int'(dac_o), 0);
    rst_i = 1'b0;
    @(negedge clk);

    // input sweep with a noise-free comparator
    for (int v = -290; v <= 290; v += 5) conv(v, 1'b0, 4'h0, 4'h0, 0, 1'b0, 1'b0);

    // every vote pattern pair for both unit steps
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        conv(3, 1'b1, 4'(a), 4'(b), 0, 1'b0, 1'b0);

    // stray starts during sampling, voting and the residue cycle (R8)
    conv(-77, 1'b0, 4'h0, 4'h0, 2, 1'b0, 1'b0);
    conv(41, 1'b1, 4'h6, 4'h9, 13, 1'b0, 1'b0);
    conv(200, 1'b0, 4'h0, 4'h0, 20, 1'b0, 1'b0);

    // start in the done cycle: back-to-back conversions (R8)
    conv(120, 1'b0, 4'h0, 4'h0, 0, 1'b0, 1'b1);
    conv(-35, 1'b1, 4'h3, 4'hE, 0, 1'b1, 1'b1);
    conv(0, 1'b1, 4'h5, 4'h5, 0, 1'b1, 1'b0);

    // reset in the middle of a conversion (R9)
    vin = 90; forced = 1'b0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (6) @(negedge clk);
    rst_i = 1'b1;
    @(negedge clk);
    rst_i = 1'b0;
    chk(dac_o == '0 && code_o == '0, "R9 reset mid conversion clears state", int'(dac_o), 0);
    chk(!samp_o && !fire_o && !rescap_o && !done_o, "R9 strobes low after reset",
        {samp_o, fire_o, rescap_o, done_o}, 0);
    repeat (25) begin
      @(negedge clk);
      chk(!fire_o && !rescap_o && !done_o, "R9 stays idle after reset", fire_o, 0);
    end
    conv(-5, 1'b0, 4'h0, 4'h0, 0, 1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule